// File: doc/BRIEF.md
# Vector Pairwise Intersection Mask Unit

This unit takes two packed vectors and reports, for each side, which of its elements also occur somewhere in the other side. Every element of the first source is compared with every element of the second source. Two bit masks come out of one request. The first mask marks the first-source elements that have a partner. The second mask marks the second-source elements that have a partner.

The elements are either 32 or 64 bits wide, over a vector span of 128, 256 or 512 bits. The second operand may come from a single scalar that is copied into every lane. Both masks go into an eight-entry, 16-bit mask register file. They land in an even/odd pair of entries, chosen by the destination id with its low bit cleared. A request that asks for merge-masking or zero-masking is refused with an error pulse, and so is one with an undefined length code. A refused request writes nothing. A combinational read port lets any mask entry be observed.

Top module: `vpi_intersect_unit`

## Requirements
- R1: In 32-bit mode, bit i of the even-entry mask is 1 exactly when first-source element i equals some active second-source element.
- R2: Bit j of the odd-entry mask is 1 exactly when second-source element j equals some active first-source element, so either both masks are zero or neither is.
- R3: With `req_esz`=1, elements are 64 bits wide and equality needs all 64 bits to match. A match in only one 32-bit half sets no bit. The lane count is 2, 4 or 8.
- R4: `req_vlen` codes 0, 1 and 2 select 128, 256 and 512 bits. Lanes at or beyond the active count are left out of the comparison. Both written entries are cleared across all 16 bits, so bits at or above the lane count read 0.
- R5: The first mask is written to entry (`req_dest` with bit 0 cleared) and the second mask to that entry plus one. All other entries keep their values.
- R6: With `req_bcast`=1, every second-operand lane takes `req_scalar`. That is bits 31:0 in 32-bit mode and bits 63:0 in 64-bit mode, and `req_src2` is ignored.
- R7: A valid request with a nonzero `req_wmask_sel` or with `req_zeroing`=1 raises `err` for one cycle, raises no `done`, and writes no entry.
- R8: An accepted request writes its pair at the next rising edge. `done` is high for exactly the one cycle after that edge, and the new masks are readable on `rd_mask` during that cycle.
- R9: While reset is held, and in the cycle after it, all entries read 0 and `done` and `err` are low.
- R10: `req_vlen`=3 is reserved. A valid request with it is refused exactly as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_src1 | input | 512 | First source vector |
| req_src2 | input | 512 | Second source vector |
| req_scalar | input | 64 | Scalar used for the second operand in broadcast mode |
| req_bcast | input | 1 | 1: copy the scalar into every second-operand lane |
| req_esz | input | 1 | Element size, 0 = 32 bit, 1 = 64 bit |
| req_vlen | input | 2 | Vector span, 0 = 128, 1 = 256, 2 = 512, 3 = reserved |
| req_dest | input | 3 | Destination entry id; the pair base is this id with bit 0 cleared |
| req_wmask_sel | input | 3 | Write-mask selector, must be zero |
| req_zeroing | input | 1 | Zeroing flag, must be zero |
| done | output | 1 | One-cycle pulse after an accepted request |
| err | output | 1 | One-cycle pulse after a refused request |
| rd_idx | input | 3 | Read port entry index |
| rd_mask | output | 16 | Contents of entry `rd_idx` |

## Verification
The bench builds the unit with the package defaults: a 512-bit span, a 32-bit base lane, sixteen 32-bit lanes and eight mask entries. This makes the full 16×16 comparison grid reachable, and with it the top mask bit. It also covers the 64-bit pairing of neighbouring lanes, where a half-match is only possible because the 64-bit compare is built from two 32-bit compares. At this size, a short span written over a pair that once held sixteen set bits shows whether the upper bits are cleared. Checks on odd destination ids and on every entry after each request show whether a write ever strays outside its pair.

// File: rtl/vpi_pkg.sv
package vpi_pkg;

    parameter int VEC_W      = 512;
    parameter int BASE_W     = 32;
    parameter int SCALAR_W   = 2 * BASE_W;
    parameter int NUM_MREG   = 8;

    localparam int LANES32    = VEC_W / BASE_W;
    localparam int MASK_W     = LANES32;
    localparam int MIN_LANES  = 128 / BASE_W;
    localparam int MREG_IDX_W = $clog2(NUM_MREG);

    typedef enum logic {
        ESZ_DWORD = 1'b0,
        ESZ_QWORD = 1'b1
    } esz_e;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_RSVD = 2'd3
    } vlen_e;

    typedef struct packed {
        logic [MREG_IDX_W-1:0] base;
        logic [MASK_W-1:0]     even_mask;
        logic [MASK_W-1:0]     odd_mask;
    } pair_wr_t;

    // Active 32-bit lanes for a given span code.
    function automatic logic [LANES32-1:0] span_lanes32(vlen_e vl);
        logic [LANES32-1:0] m;
        for (int k = 0; k < LANES32; k++)
            m[k] = (k < (MIN_LANES << int'(vl)));
        return m;
    endfunction

    // Valid element bits for a given element size and span code.
    function automatic logic [MASK_W-1:0] elem_valid_mask(esz_e esz, vlen_e vl);
        logic [MASK_W-1:0] m;
        int n;
        n = MIN_LANES << int'(vl);
        if (esz == ESZ_QWORD) n = n / 2;
        for (int k = 0; k < MASK_W; k++)
            m[k] = (k < n);
        return m;
    endfunction

endpackage

// File: rtl/vpi_operand_prep.sv
module vpi_operand_prep
    import vpi_pkg::*;
(
    input  logic [VEC_W-1:0]    src2,
    input  logic [SCALAR_W-1:0] scalar,
    input  logic                bcast,
    input  esz_e                esz,
    output logic [VEC_W-1:0]    op2
);
    generate
        for (genvar k = 0; k < LANES32; k++) begin : g_lane
            logic [BASE_W-1:0] rep;
            always_comb begin
                if (esz == ESZ_QWORD)
                    rep = scalar[(k % 2) * BASE_W +: BASE_W];
                else
                    rep = scalar[BASE_W-1:0];
            end
            assign op2[k*BASE_W +: BASE_W] = bcast ? rep : src2[k*BASE_W +: BASE_W];
        end
    endgenerate
endmodule

// File: rtl/vpi_match_matrix.sv
module vpi_match_matrix
    import vpi_pkg::*;
(
    input  logic [VEC_W-1:0]   op1,
    input  logic [VEC_W-1:0]   op2,
    input  esz_e               esz,
    input  logic [LANES32-1:0] act32,
    output logic [MASK_W-1:0]  mask1,
    output logic [MASK_W-1:0]  mask2
);
    localparam int L = LANES32;

    // Shared 32-bit equality grid; 64-bit matches are built from pairs.
    logic [L*L-1:0] eq;

    generate
        for (genvar gi = 0; gi < L; gi++) begin : g_row
            for (genvar gj = 0; gj < L; gj++) begin : g_col
                assign eq[gi*L + gj] = (op1[gi*BASE_W +: BASE_W] == op2[gj*BASE_W +: BASE_W]);
            end
        end
    endgenerate

    always_comb begin
        mask1 = '0;
        mask2 = '0;
        if (esz == ESZ_QWORD) begin
            for (int i = 0; i < L/2; i++) begin
                for (int j = 0; j < L/2; j++) begin
                    if (eq[(2*i)*L + 2*j] && eq[(2*i+1)*L + 2*j+1] &&
                        act32[2*i] && act32[2*j]) begin
                        mask1[i] = 1'b1;
                        mask2[j] = 1'b1;
                    end
                end
            end
        end else begin
            for (int i = 0; i < L; i++) begin
                for (int j = 0; j < L; j++) begin
                    if (eq[i*L + j] && act32[i] && act32[j]) begin
                        mask1[i] = 1'b1;
                        mask2[j] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vpi_mask_rf.sv
module vpi_mask_rf
    import vpi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  pair_wr_t              wr,
    input  logic [MREG_IDX_W-1:0] rd_idx,
    output logic [MASK_W-1:0]     rd_data
);
    logic [MASK_W-1:0] regs [NUM_MREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_MREG; k++) regs[k] <= '0;
        end else if (wr_en) begin
            regs[{wr.base[MREG_IDX_W-1:1], 1'b0}] <= wr.even_mask;
            regs[{wr.base[MREG_IDX_W-1:1], 1'b1}] <= wr.odd_mask;
        end
    end

    assign rd_data = regs[rd_idx];

    assert_pair_even_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[{$past(wr.base[MREG_IDX_W-1:1]), 1'b0}] == $past(wr.even_mask));

    assert_pair_odd_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[{$past(wr.base[MREG_IDX_W-1:1]), 1'b1}] == $past(wr.odd_mask));

    assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs[rd_idx] == $past(regs[rd_idx]) || rd_idx != $past(rd_idx));
endmodule

// File: rtl/vpi_intersect_unit.sv
module vpi_intersect_unit
    import vpi_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [VEC_W-1:0]      req_src1,
    input  logic [VEC_W-1:0]      req_src2,
    input  logic [SCALAR_W-1:0]   req_scalar,
    input  logic                  req_bcast,
    input  logic                  req_esz,
    input  logic [1:0]            req_vlen,
    input  logic [MREG_IDX_W-1:0] req_dest,
    input  logic [2:0]            req_wmask_sel,
    input  logic                  req_zeroing,
    output logic                  done,
    output logic                  err,
    input  logic [MREG_IDX_W-1:0] rd_idx,
    output logic [MASK_W-1:0]     rd_mask
);
    esz_e               esz;
    vlen_e              vl;
    logic [VEC_W-1:0]   op2;
    logic [LANES32-1:0] act32;
    logic [MASK_W-1:0]  m1, m2;
    logic               legal, accept, refuse;
    pair_wr_t           wr;
    logic               done_q, err_q;

    assign esz    = esz_e'(req_esz);
    assign vl     = vlen_e'(req_vlen);
    assign act32  = span_lanes32(vl);
    assign legal  = (req_wmask_sel == '0) && !req_zeroing && (vl != VL_RSVD);
    assign accept = req_valid && legal;
    assign refuse = req_valid && !legal;

    vpi_operand_prep u_prep (
        .src2   (req_src2),
        .scalar (req_scalar),
        .bcast  (req_bcast),
        .esz    (esz),
        .op2    (op2)
    );

    vpi_match_matrix u_matrix (
        .op1   (req_src1),
        .op2   (op2),
        .esz   (esz),
        .act32 (act32),
        .mask1 (m1),
        .mask2 (m2)
    );

    assign wr.base      = req_dest;
    assign wr.even_mask = m1;
    assign wr.odd_mask  = m2;

    vpi_mask_rf u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr      (wr),
        .rd_idx  (rd_idx),
        .rd_data (rd_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= accept;
            err_q  <= refuse;
        end
    end

    assign done = done_q;
    assign err  = err_q;

    assert_accept_done_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> done && !err);

    assert_refuse_err_R7: assert property (@(posedge clk) disable iff (rst)
        refuse |=> err && !done);

    assert_done_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !done && !err);

    assert_mask_symmetry_R2: assert property (@(posedge clk) disable iff (rst)
        accept |-> ((m1 == '0) == (m2 == '0)));

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
        accept |-> ((m1 | m2) & ~elem_valid_mask(esz, vl)) == '0);

    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> !done && !err);
endmodule

// File: tb/vpi_intersect_unit_test.sv
module vpi_intersect_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [511:0] req_src1, req_src2;
    logic [63:0]  req_scalar;
    logic         req_bcast, req_esz;
    logic [1:0]   req_vlen;
    logic [2:0]   req_dest, req_wmask_sel;
    logic         req_zeroing;
    logic         done, err;
    logic [2:0]   rd_idx;
    logic [15:0]  rd_mask;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_rf [8];

    always #5 clk = ~clk;

    vpi_intersect_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_src1(req_src1), .req_src2(req_src2), .req_scalar(req_scalar),
        .req_bcast(req_bcast), .req_esz(req_esz), .req_vlen(req_vlen),
        .req_dest(req_dest), .req_wmask_sel(req_wmask_sel), .req_zeroing(req_zeroing),
        .done(done), .err(err), .rd_idx(rd_idx), .rd_mask(rd_mask)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [511:0] rand_vec();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference model: nested loops over element pairs.
    task automatic ref_masks(input logic [511:0] a, input logic [511:0] b, input logic [63:0] s,
                             input logic bc, input logic q, input int vl,
                             output logic [15:0] m1, output logic [15:0] m2);
        int esz, lanes;
        logic [63:0] ea, eb;
        esz   = q ? 64 : 32;
        lanes = (128 << vl) / esz;
        m1 = '0;
        m2 = '0;
        for (int i = 0; i < lanes; i++) begin
            for (int j = 0; j < lanes; j++) begin
                if (q) begin
                    ea = a[i*64 +: 64];
                    eb = bc ? s : b[j*64 +: 64];
                end else begin
                    ea = {32'b0, a[i*32 +: 32]};
                    eb = {32'b0, bc ? s[31:0] : b[j*32 +: 32]};
                end
                if (ea == eb) begin
                    m1[i] = 1'b1;
                    m2[j] = 1'b1;
                end
            end
        end
    endtask

    task automatic check_all_regs(input string req);
        for (int k = 0; k < 8; k++) begin
            rd_idx = 3'(k);
            #1;
            check(req, {16'b0, rd_mask}, {16'b0, exp_rf[k]});
        end
    endtask

    task automatic run_op(input string req, input logic [511:0] a, input logic [511:0] b,
                          input logic [63:0] s, input logic bc, input logic q, input logic [1:0] vl,
                          input logic [2:0] dest, input logic [2:0] wsel, input logic zr);
        logic ok;
        logic [15:0] m1, m2;
        ok = (wsel == 3'd0) && !zr && (vl != 2'd3);
        if (ok) ref_masks(a, b, s, bc, q, int'(vl), m1, m2);
        @(negedge clk);
        req_src1 = a; req_src2 = b; req_scalar = s; req_bcast = bc; req_esz = q;
        req_vlen = vl; req_dest = dest; req_wmask_sel = wsel; req_zeroing = zr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " done R8"}, {31'b0, done}, {31'b0, ok});
        check({req, " err R7"},  {31'b0, err},  {31'b0, !ok});
        if (ok) begin
            exp_rf[{dest[2:1], 1'b0}] = m1;
            exp_rf[{dest[2:1], 1'b1}] = m2;
        end
        check_all_regs({req, " R5 entries"});
        @(negedge clk);
        check({req, " pulse width R8"}, {30'b0, done, err}, 32'd0);
    endtask

    task automatic t_reset();
        check("R9 done", {31'b0, done}, 32'd0);
        check("R9 err",  {31'b0, err},  32'd0);
        check_all_regs("R9 entries");
    endtask

    task automatic t_dword_full();
        logic [511:0] a, b;
        a = rand_vec(); b = rand_vec();
        b[3*32 +: 32]  = a[0 +: 32];
        b[15*32 +: 32] = a[15*32 +: 32];
        b[7*32 +: 32]  = a[9*32 +: 32];
        b[8*32 +: 32]  = a[9*32 +: 32];
        run_op("R1 R2 dword 512", a, b, 64'd0, 0, 0, 2'd2, 3'd0, 3'd0, 0);
        check("R1 bit15", {16'b0, exp_rf[0]} & 32'h8001, 32'h8001);
    endtask

    task automatic t_qword_full();
        logic [511:0] a, b;
        a = rand_vec(); b = rand_vec();
        b[2*64 +: 64] = a[7*64 +: 64];
        b[6*64 +: 64] = a[1*64 +: 64];
        run_op("R3 qword 512", a, b, 64'd0, 0, 1, 2'd2, 3'd2, 3'd0, 0);
        check("R3 upper zero", {16'b0, exp_rf[2] & 16'hFF00}, 32'd0);
    endtask

    task automatic t_halfmatch();
        logic [511:0] a, b;
        a = rand_vec(); b = rand_vec();
        b[3*64 +: 32]      = a[0 +: 32];
        b[5*64 + 32 +: 32] = a[32 +: 32];
        run_op("R3 half match", a, b, 64'd0, 0, 1, 2'd2, 3'd6, 3'd0, 0);
        check("R3 half none", {16'b0, exp_rf[6] | exp_rf[7]}, 32'd0);
    endtask

    task automatic t_short_span();
        logic [511:0] a, b;
        a = rand_vec(); b = a;
        b[0 +: 32] = ~a[0 +: 32];
        run_op("R4 prefill", a, a, 64'd0, 0, 0, 2'd2, 3'd4, 3'd0, 0);
        check("R4 prefill full", {16'b0, exp_rf[4]}, 32'h0000FFFF);
        // stale upper lanes agree everywhere; only lanes 0..3 count
        run_op("R4 dword 128", a, b, 64'd0, 0, 0, 2'd0, 3'd4, 3'd0, 0);
        check("R4 cleared upper", {16'b0, exp_rf[4]}, 32'h0000000E);
        run_op("R4 qword 256", a, a, 64'd0, 0, 1, 2'd1, 3'd4, 3'd0, 0);
        check("R4 qword 256 bits", {16'b0, exp_rf[5]}, 32'h0000000F);
    endtask

    task automatic t_odd_dest();
        logic [511:0] a;
        a = rand_vec();
        run_op("R5 odd dest", a, a, 64'd0, 0, 1, 2'd2, 3'd5, 3'd0, 0);
        check("R5 even gets first", {16'b0, exp_rf[4]}, 32'h000000FF);
    endtask

    task automatic t_bcast();
        logic [511:0] a, b;
        logic [63:0] s;
        a = rand_vec(); b = rand_vec(); s = {$urandom, $urandom};
        a[5*32 +: 32] = s[31:0];
        b[0 +: 32] = a[0 +: 32];
        run_op("R6 bcast dword", a, b, s, 1, 0, 2'd2, 3'd1, 3'd0, 0);
        check("R6 dword first", {16'b0, exp_rf[0]}, 32'h00000020);
        check("R6 dword second", {16'b0, exp_rf[1]}, 32'h0000FFFF);
        a = rand_vec();
        a[3*64 +: 64] = s;
        a[0 +: 32] = s[31:0];
        run_op("R6 bcast qword", a, b, s, 1, 1, 2'd1, 3'd3, 3'd0, 0);
        check("R6 qword first", {16'b0, exp_rf[2]}, 32'h00000008);
        check("R6 qword second", {16'b0, exp_rf[3]}, 32'h0000000F);
    endtask

    task automatic t_refuse();
        logic [511:0] a;
        a = rand_vec();
        run_op("R7 wmask sel", a, a, 64'd0, 0, 0, 2'd2, 3'd0, 3'd3, 0);
        run_op("R7 zeroing", a, a, 64'd0, 0, 0, 2'd2, 3'd6, 3'd0, 1);
        run_op("R10 reserved span", a, a, 64'd0, 0, 0, 2'd3, 3'd2, 3'd0, 0);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_rf[k] = '0;
        rst = 1'b1; req_valid = 1'b0; rd_idx = '0;
        req_src1 = '0; req_src2 = '0; req_scalar = '0; req_bcast = 0; req_esz = 0;
        req_vlen = 2'd2; req_dest = '0; req_wmask_sel = '0; req_zeroing = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dword_full();
        t_qword_full();
        t_halfmatch();
        t_short_span();
        t_odd_dest();
        t_bcast();
        t_refuse();
        for (int r = 0; r < 20; r++) begin
            logic [511:0] a, b;
            a = rand_vec(); b = rand_vec();
            for (int k = 0; k < 4; k++) b[($urandom % 16)*32 +: 32] = a[($urandom % 16)*32 +: 32];
            run_op("R1 R2 R3 sweep", a, b, 64'd0, 0, 1'($urandom), 2'($urandom % 3),
                   3'($urandom), 3'd0, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule